// File: doc/BRIEF.md
# PCIe Root Interrupt Aggregator

This block gathers the interrupt events seen by a PCIe root port and reduces them to one interrupt line for the host. Legacy INTx assert and deassert pulses, message-signalled interrupt (MSI) arrivals and two link events (power-state change, flush) each set a sticky status bit. Every status register has a mask register beside it. A 1 in a mask bit stops that status bit from reaching the next level. Software clears a status bit by writing 1 to it.

There are two levels of aggregation. The per-vector MSI status feeds a single MSI-pending bit in the primary status register. The primary and secondary status registers then feed a core bit in a host summary register. The output interrupt is taken from that core bit. Each level adds one register stage. An INTx event therefore reaches the output two edges after it arrives, and an MSI arrival reaches it three edges after it arrives.

Top module: `pirq_agg`

## Requirements
- R1: A pulse on INTx assert line k (k = 0..3) sets primary status bit 16+k. A pulse on INTx deassert line k sets primary status bit 20+k. Each bit is set at the clock edge that samples the pulse.
- R2: A power-state pulse sets secondary status bit 4. A flush pulse sets secondary status bit 5.
- R3: An MSI arrival with vector v sets MSI status bit v. It also stores the low 8 bits of its payload in the payload register (bits 7:0). The payload register always holds the payload of the most recent arrival.
- R4: Writing 1 to a bit of any status register (primary, secondary, MSI, host summary) clears that bit. Writing 0 to a bit leaves it unchanged.
- R5: If an event sets a status bit in the same cycle that software writes 1 to clear it, the bit stays set.
- R6: Primary status bit 24 is set one edge after any MSI status bit is pending with its MSI mask bit at 0.
- R7: Host summary bit 16 is set one edge after any primary or secondary status bit is pending with its mask bit at 0. A masked status bit never sets it.
- R8: `irq_o` is high exactly while host summary bit 16 is set and host mask bit 16 is 0.
- R9: Reset values are as follows. All status registers and the payload register are 0. The primary mask is 0x07FFFFFF, the secondary mask is 0x00000030, the MSI mask is 0xFFFFFFFF and the host mask is 0x00FFF0FB. `irq_o` is low.
- R10: The register map is addressed by `reg_addr`: 0 primary status, 1 primary mask, 2 secondary status, 3 secondary mask, 4 MSI status, 5 MSI mask, 6 MSI payload, 7 host summary, 8 host mask. Bits that are not implemented read as 0. The implemented bits are primary [26:0], secondary [5:4], payload [7:0], host summary [16] and host mask bits set in 0x00FFF0FB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| intx_asrt_i | input | 4 | INTx assert event pulses, one per line |
| intx_dasrt_i | input | 4 | INTx deassert event pulses, one per line |
| msi_vld_i | input | 1 | MSI arrival strobe |
| msi_vec_i | input | 5 | MSI vector index |
| msi_data_i | input | 8 | MSI payload |
| pwr_evt_i | input | 1 | Power-state change event pulse |
| flush_evt_i | input | 1 | Flush event pulse |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bound checker tests the following on every cycle. Events set their status bits. An unmasked MSI vector sets the pending bit, and unmasked status sets the core bit. A pending bit stays set until it is written with 1. An event beats a same-cycle clear. The summary line stays high until the core bit is cleared or masked. Only the bench scenarios can show the reset values of the register map, the zero reads of unimplemented bits and the payload readback. They also show the whole latency from an event to `irq_o`, and that a status bit whose mask is 1 never raises the summary.

// File: rtl/pirq_agg.sv
module pirq_agg #(
  parameter int NUM_MSI = 32,
  localparam int VW = $clog2(NUM_MSI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [3:0]    intx_asrt_i,
  input  logic [3:0]    intx_dasrt_i,
  input  logic          msi_vld_i,
  input  logic [VW-1:0] msi_vec_i,
  input  logic [7:0]    msi_data_i,
  input  logic          pwr_evt_i,
  input  logic          flush_evt_i,
  output logic          irq_o
);
  localparam logic [23:0] HOST_MSK_ALL = 24'hFFF0FB;

  logic [26:0]        isr0_q, isr0_msk_q;
  logic [1:0]         isr1_q, isr1_msk_q;
  logic [NUM_MSI-1:0] msi_st_q, msi_msk_q;
  logic [7:0]         msi_pl_q;
  logic               host_core_q;
  logic [23:0]        host_msk_q;

  wire wr_isr0  = reg_we && reg_addr == 4'd0;
  wire wr_isr0m = reg_we && reg_addr == 4'd1;
  wire wr_isr1  = reg_we && reg_addr == 4'd2;
  wire wr_isr1m = reg_we && reg_addr == 4'd3;
  wire wr_msi   = reg_we && reg_addr == 4'd4;
  wire wr_msim  = reg_we && reg_addr == 4'd5;
  wire wr_host  = reg_we && reg_addr == 4'd7;
  wire wr_hostm = reg_we && reg_addr == 4'd8;

  wire msi_pend  = |(msi_st_q & ~msi_msk_q);
  wire core_pend = (|(isr0_q & ~isr0_msk_q)) | (|(isr1_q & ~isr1_msk_q));

  wire [26:0] isr0_set = {2'b00, msi_pend, intx_dasrt_i, intx_asrt_i, 16'h0000};
  wire [1:0]  isr1_set = {flush_evt_i, pwr_evt_i};
  wire [NUM_MSI-1:0] msi_set = msi_vld_i ? (NUM_MSI'(1) << msi_vec_i) : '0;

  wire [26:0]        isr0_clr = wr_isr0 ? reg_wdata[26:0] : '0;
  wire [1:0]         isr1_clr = wr_isr1 ? reg_wdata[5:4] : '0;
  wire [NUM_MSI-1:0] msi_clr  = wr_msi ? reg_wdata[NUM_MSI-1:0] : '0;
  wire               host_clr = wr_host & reg_wdata[16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr0_q      <= '0;
      isr0_msk_q  <= '1;
      isr1_q      <= '0;
      isr1_msk_q  <= '1;
      msi_st_q    <= '0;
      msi_msk_q   <= '1;
      msi_pl_q    <= '0;
      host_core_q <= 1'b0;
      host_msk_q  <= HOST_MSK_ALL;
    end else begin
      isr0_q      <= (isr0_q & ~isr0_clr) | isr0_set;
      isr1_q      <= (isr1_q & ~isr1_clr) | isr1_set;
      msi_st_q    <= (msi_st_q & ~msi_clr) | msi_set;
      host_core_q <= (host_core_q & ~host_clr) | core_pend;
      if (msi_vld_i) msi_pl_q <= msi_data_i;
      if (wr_isr0m)  isr0_msk_q <= reg_wdata[26:0];
      if (wr_isr1m)  isr1_msk_q <= reg_wdata[5:4];
      if (wr_msim)   msi_msk_q  <= reg_wdata[NUM_MSI-1:0];
      if (wr_hostm)  host_msk_q <= reg_wdata[23:0] & HOST_MSK_ALL;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {5'b0, isr0_q};
      4'd1:    reg_rdata = {5'b0, isr0_msk_q};
      4'd2:    reg_rdata = {26'b0, isr1_q, 4'b0};
      4'd3:    reg_rdata = {26'b0, isr1_msk_q, 4'b0};
      4'd4:    reg_rdata = 32'(msi_st_q);
      4'd5:    reg_rdata = 32'(msi_msk_q);
      4'd6:    reg_rdata = {24'b0, msi_pl_q};
      4'd7:    reg_rdata = {15'b0, host_core_q, 16'b0};
      4'd8:    reg_rdata = {8'b0, host_msk_q};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = host_core_q & ~host_msk_q[16];
endmodule

// File: rtl/pirq_agg_chk.sv
module pirq_agg_chk #(
  parameter int NUM_MSI = 32,
  localparam int VW = $clog2(NUM_MSI)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [3:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [3:0]         intx_asrt_i,
  input logic [3:0]         intx_dasrt_i,
  input logic               msi_vld_i,
  input logic [VW-1:0]      msi_vec_i,
  input logic [7:0]         msi_data_i,
  input logic               pwr_evt_i,
  input logic               flush_evt_i,
  input logic               irq_o,
  input logic [26:0]        isr0_q,
  input logic [26:0]        isr0_msk_q,
  input logic [1:0]         isr1_q,
  input logic [1:0]         isr1_msk_q,
  input logic [NUM_MSI-1:0] msi_st_q,
  input logic [NUM_MSI-1:0] msi_msk_q,
  input logic [7:0]         msi_pl_q,
  input logic               host_core_q,
  input logic [23:0]        host_msk_q
);
  wire clr_pwr  = reg_we && reg_addr == 4'd2 && reg_wdata[4];
  wire clr_fl   = reg_we && reg_addr == 4'd2 && reg_wdata[5];
  wire clr_host = reg_we && reg_addr == 4'd7 && reg_wdata[16];
  wire wr_hm    = reg_we && reg_addr == 4'd8;
  wire pend_any = (|(isr0_q & ~isr0_msk_q)) || (|(isr1_q & ~isr1_msk_q));

  AST_INTX_ASSERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_asrt_i) |=> ((isr0_q[19:16] & $past(intx_asrt_i)) == $past(intx_asrt_i))); // R1
  AST_INTX_DEASSERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_dasrt_i) |=> ((isr0_q[23:20] & $past(intx_dasrt_i)) == $past(intx_dasrt_i))); // R1
  AST_PWR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_evt_i |=> isr1_q[0]); // R2
  AST_FLUSH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt_i |=> isr1_q[1]); // R2
  AST_MSI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    msi_vld_i |=> (msi_st_q[$past(msi_vec_i)] && msi_pl_q == $past(msi_data_i))); // R3
  AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pwr && !pwr_evt_i) |=> !isr1_q[0]); // R4
  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isr1_q[0] && !clr_pwr) |=> isr1_q[0]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_evt_i && clr_fl) |=> isr1_q[1]); // R5
  AST_MSI_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|(msi_st_q & ~msi_msk_q)) |=> isr0_q[24]); // R6
  AST_CORE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |=> host_core_q); // R7
  AST_CORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_any && !host_core_q) |=> !host_core_q); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_host && !wr_hm) |=> irq_o); // R8
endmodule

bind pirq_agg pirq_agg_chk #(.NUM_MSI(NUM_MSI)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .intx_asrt_i(intx_asrt_i), .intx_dasrt_i(intx_dasrt_i),
  .msi_vld_i(msi_vld_i), .msi_vec_i(msi_vec_i), .msi_data_i(msi_data_i),
  .pwr_evt_i(pwr_evt_i), .flush_evt_i(flush_evt_i), .irq_o(irq_o),
  .isr0_q(isr0_q), .isr0_msk_q(isr0_msk_q), .isr1_q(isr1_q),
  .isr1_msk_q(isr1_msk_q), .msi_st_q(msi_st_q), .msi_msk_q(msi_msk_q),
  .msi_pl_q(msi_pl_q), .host_core_q(host_core_q), .host_msk_q(host_msk_q)
);

// File: tb/pirq_agg_tb.sv
`timescale 1ns/1ps
module pirq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  intx_asrt_i = '0, intx_dasrt_i = '0;
  logic        msi_vld_i = 1'b0;
  logic [4:0]  msi_vec_i = '0;
  logic [7:0]  msi_data_i = '0;
  logic        pwr_evt_i = 1'b0, flush_evt_i = 1'b0;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  pirq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_asrt_i(intx_asrt_i),
    .intx_dasrt_i(intx_dasrt_i), .msi_vld_i(msi_vld_i), .msi_vec_i(msi_vec_i),
    .msi_data_i(msi_data_i), .pwr_evt_i(pwr_evt_i), .flush_evt_i(flush_evt_i),
    .irq_o(irq_o)
  );

  initial begin : monitor
    item_t it;
    logic [31:0] got;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        got = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.addr, got, it.exp);
        end
      end
    end
  end

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string r);
    reg_addr = a;
    q.push_back('{1'b0, a, e, r});
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string r);
    q.push_back('{1'b1, 4'd0, {31'b0, e}, r});
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic msi(input logic [4:0] v, input logic [7:0] d);
    msi_vld_i = 1'b1; msi_vec_i = v; msi_data_i = d;
    @(negedge clk);
    msi_vld_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset state
    exp_reg(4'd0, 32'h0, "R9 primary status");
    exp_reg(4'd1, 32'h07FFFFFF, "R9 primary mask");
    exp_reg(4'd3, 32'h30, "R9 secondary mask");
    exp_reg(4'd4, 32'h0, "R9 msi status");
    exp_reg(4'd5, 32'hFFFFFFFF, "R9 msi mask");
    exp_reg(4'd6, 32'h0, "R9 payload");
    exp_reg(4'd8, 32'h00FFF0FB, "R9 host mask");
    exp_irq(1'b0, "R9 irq");
    // R10 unimplemented bits read zero
    wr(4'd3, 32'hFFFFFFFF);
    exp_reg(4'd3, 32'h30, "R10 secondary mask width");

    // R1 assert line 2, masked
    intx_asrt_i = 4'b0100; @(negedge clk); intx_asrt_i = '0;
    exp_reg(4'd0, 32'h00040000, "R1 assert line 2");
    idle(2);
    exp_reg(4'd7, 32'h0, "R7 masked source blocked");
    // R7 unmask bit 18
    wr(4'd1, 32'h07FBFFFF);
    idle(1);
    exp_reg(4'd7, 32'h00010000, "R7 core bit set");
    exp_irq(1'b0, "R8 host mask blocks irq");
    wr(4'd8, 32'h00FEF0FB);
    exp_irq(1'b1, "R8 irq asserted");
    // R4 write zero keeps, write one clears
    wr(4'd0, 32'h0);
    exp_reg(4'd0, 32'h00040000, "R4 zero write keeps");
    wr(4'd0, 32'h00040000);
    exp_reg(4'd0, 32'h0, "R4 primary cleared");
    wr(4'd7, 32'h0);
    exp_irq(1'b1, "R4 host zero write keeps");
    wr(4'd7, 32'h00010000);
    exp_reg(4'd7, 32'h0, "R4 host cleared");
    exp_irq(1'b0, "R8 irq released");
    // R1 deassert line 1
    intx_dasrt_i = 4'b0010; @(negedge clk); intx_dasrt_i = '0;
    exp_reg(4'd0, 32'h00200000, "R1 deassert line 1");
    wr(4'd0, 32'h00200000);
    exp_reg(4'd0, 32'h0, "R4 deassert bit cleared");

    // R2 secondary events
    pwr_evt_i = 1'b1; @(negedge clk); pwr_evt_i = 1'b0;
    flush_evt_i = 1'b1; @(negedge clk); flush_evt_i = 1'b0;
    exp_reg(4'd2, 32'h30, "R2 power and flush");
    // R5 set wins over same-cycle clear
    flush_evt_i = 1'b1; reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h20;
    @(negedge clk);
    flush_evt_i = 1'b0; reg_we = 1'b0;
    exp_reg(4'd2, 32'h30, "R5 set wins");
    wr(4'd2, 32'h10);
    exp_reg(4'd2, 32'h20, "R4 partial clear");
    // R7 secondary path to irq
    wr(4'd3, 32'h10);
    idle(1);
    exp_irq(1'b1, "R7 secondary source irq");
    wr(4'd2, 32'h20);
    wr(4'd7, 32'h00010000);
    exp_reg(4'd7, 32'h0, "R7 core cleared");
    exp_irq(1'b0, "R8 irq low after clear");

    // R3 MSI while masked
    msi(5'd7, 8'hA5);
    exp_reg(4'd4, 32'h00000080, "R3 msi vector 7");
    exp_reg(4'd6, 32'h000000A5, "R3 payload");
    exp_reg(4'd0, 32'h0, "R6 masked msi no pending");
    // R6 unmask vector 7
    wr(4'd5, 32'hFFFFFF7F);
    idle(1);
    exp_reg(4'd0, 32'h01000000, "R6 msi pending");
    msi(5'd31, 8'h3C);
    exp_reg(4'd4, 32'h80000080, "R3 msi vector 31");
    exp_reg(4'd6, 32'h0000003C, "R3 latest payload");
    wr(4'd4, 32'h0);
    exp_reg(4'd4, 32'h80000080, "R4 msi zero write keeps");
    wr(4'd0, 32'h01000000);
    exp_reg(4'd0, 32'h01000000, "R6 pending persists");
    wr(4'd4, 32'h80000080);
    exp_reg(4'd4, 32'h0, "R4 msi cleared");
    wr(4'd0, 32'h01000000);
    exp_reg(4'd0, 32'h0, "R6 pending cleared");
    exp_irq(1'b0, "R7 masked msi pending no irq");

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule